// File: doc/BRIEF.md
# Clock Ratio Change Sequencer

This block turns one reference clock into three clock-enable strobes, one each for the processor core, the system bus and the peripheral domain. Each strobe's divide ratio is picked by a 3-bit code written over a small register port. A divider takes up a new code only at the end of its current divided period, so no strobe ever comes early or is cut short.

Most ratio changes apply without delay. The bus-ratio code is the exception when the `pll2_en` input is high. Writing it then starts a stabilization wait. During the wait `halt_o` is raised, all three internal strobes are held low, and an up-counter runs from a programmed start value until it wraps. At the wrap the counter stops, the strobes come back and the halt drops. Software loads the counter start value through the same port before it writes the bus ratio.

The external clock pad carries the raw bus strobe, and it keeps running during a wait, when its pattern may be irregular. Software can instead release the pad to high impedance. While released, the pad output reads as the pulled-up level, logic 1.

Top module: `clk_ratio_sequencer`

## Requirements
- R1: Each ratio field maps codes 0 to 5 to divide-by 1, 2, 3, 4, 6 and 8. The matching strobe is high for one reference cycle in every N cycles. After reset every field holds code 0 (divide-by 1).
- R2: Writing code 6 or 7 to a ratio field leaves that domain's ratio unchanged and starts no wait.
- R3: A new ratio takes effect only at the end of the current divided period. Every interval between strobes is either the old period or the new one.
- R4: With `pll2_en` high, a valid bus-ratio write accepted at a clock edge raises `halt_o` from that edge. `halt_o` stays high for exactly 2^CNT_W − P cycles, where P is the programmed start value.
- R5: While `halt_o` is high, `core_en_o`, `bus_en_o` and `peri_en_o` are all low.
- R6: A bus-ratio write made while `halt_o` is high is ignored. The wait length is unchanged and the bus ratio stays the one that started the wait.
- R7: With `pll2_en` low, a bus-ratio write raises no halt, and the new ratio applies at the next bus boundary.
- R8: Core and peripheral ratio writes never raise `halt_o`, whatever the state of `pll2_en`.
- R9: The pad-control register is address 3, bit 0, and resets to 1. When the bit is 1, `ck_pad_oe` is 1 and `ck_pad_o` follows the ungated bus strobe, including during a wait. When the bit is 0, `ck_pad_oe` is 0 and `ck_pad_o` reads 1.
- R10: The register addresses are 0 for the core code, 1 for the bus code, 2 for the peripheral code, 3 for pad control and 4 for the counter start value. A ratio code sits in data bits [2:0]. The start value is used by the next wait that begins. `wr_ready` is always 1, so the port never applies back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write acceptance, always 1 |
| wr_addr | input | ADDR_W | Register select |
| wr_data | input | DATA_W | Write data |
| pll2_en | input | 1 | High when the second PLL is running |
| halt_o | output | 1 | Processor halt during a stabilization wait |
| core_en_o | output | 1 | Core clock-enable strobe |
| bus_en_o | output | 1 | Bus clock-enable strobe |
| peri_en_o | output | 1 | Peripheral clock-enable strobe |
| ck_pad_o | output | 1 | External clock pad level |
| ck_pad_oe | output | 1 | External clock pad output enable |

## Verification
A wrong divider count or a wrongly decoded code shows up at once as the wrong spacing between strobes, within one divided period of at most eight cycles. A stabilization counter that starts from the wrong value, or steps the wrong way, changes how many cycles `halt_o` stays high. That error is visible exactly when the halt drops. A divider that switches ratio outside a boundary produces an interval that matches neither the old nor the new period, so it shows in the first interval after the write.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int CODE_W = 3;
  localparam int DIV_W  = 4;
  localparam int NUM_DOM = 3;

  typedef enum logic [2:0] {
    SEL_CORE = 3'd0,
    SEL_BUS  = 3'd1,
    SEL_PERI = 3'd2,
    SEL_PAD  = 3'd3,
    SEL_PRE  = 3'd4
  } reg_sel_e;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return c <= 3'd5;
  endfunction

  function automatic logic [DIV_W-1:0] code_to_div(input logic [CODE_W-1:0] c);
    case (c)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd4;
      3'd4:    return 4'd6;
      3'd5:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/ratio_divider.sv
module ratio_divider
  import clk_ratio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              gate_i,
  output logic              tick_o,
  output logic              en_o
);
  logic [DIV_W-1:0] div_q, pend_q, cnt_q;
  logic             pend_v_q;
  logic [DIV_W-1:0] new_div;
  logic             tick;

  assign new_div = code_to_div(code_i);
  assign tick    = (cnt_q == div_q - DIV_W'(1));
  assign tick_o  = tick;
  assign en_o    = tick & ~gate_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(1);
      pend_q   <= DIV_W'(1);
      pend_v_q <= 1'b0;
      cnt_q    <= '0;
    end else if (tick) begin
      cnt_q    <= '0;
      pend_v_q <= 1'b0;
      if (load_i)        div_q <= new_div;
      else if (pend_v_q) div_q <= pend_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
      if (load_i) begin
        pend_q   <= new_div;
        pend_v_q <= 1'b1;
      end
    end
  end

  // Phase counter never passes the active period (no runt strobe)
  assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_q);
  // Period may change only right after a boundary strobe
  assert_switch_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != $past(div_q)) |-> $past(tick));
endmodule

// File: rtl/stab_counter.sv
module stab_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= preload_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CNT_MAX) busy_q <= 1'b0;
      else                  cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign busy_o = busy_q;

  // Wait ends only on counter wrap
  assert_end_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(cnt_q == CNT_MAX));
  // Counter climbs by one per cycle through the wait
  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/clk_ratio_sequencer.sv
module clk_ratio_sequencer
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pll2_en,
  output logic              halt_o,
  output logic              core_en_o,
  output logic              bus_en_o,
  output logic              peri_en_o,
  output logic              ck_pad_o,
  output logic              ck_pad_oe
);
  logic               wr_fire;
  logic [CODE_W-1:0]  code;
  logic               code_good;
  logic [NUM_DOM-1:0] load, tick, en;
  logic               halt;
  logic               start_wait;
  logic               pad_en_q;
  logic [CNT_W-1:0]   preload_q;

  assign wr_ready  = 1'b1;
  assign wr_fire   = wr_valid & wr_ready;
  assign code      = wr_data[CODE_W-1:0];
  assign code_good = code_ok(code);

  assign load[0] = wr_fire && code_good && (wr_addr == ADDR_W'(SEL_CORE));
  assign load[1] = wr_fire && code_good && (wr_addr == ADDR_W'(SEL_BUS)) && !halt;
  assign load[2] = wr_fire && code_good && (wr_addr == ADDR_W'(SEL_PERI));
  assign start_wait = load[1] & pll2_en;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    ratio_divider u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load[g]),
      .code_i (code),
      .gate_i (halt),
      .tick_o (tick[g]),
      .en_o   (en[g])
    );
  end

  stab_counter #(.CNT_W(CNT_W)) u_stab (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_wait),
    .preload_i (preload_q),
    .busy_o    (halt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_en_q  <= 1'b1;
      preload_q <= '0;
    end else if (wr_fire) begin
      if (wr_addr == ADDR_W'(SEL_PAD)) pad_en_q  <= wr_data[0];
      if (wr_addr == ADDR_W'(SEL_PRE)) preload_q <= wr_data[CNT_W-1:0];
    end
  end

  assign halt_o    = halt;
  assign core_en_o = en[0];
  assign bus_en_o  = en[1];
  assign peri_en_o = en[2];
  assign ck_pad_oe = pad_en_q;
  assign ck_pad_o  = pad_en_q ? tick[1] : 1'b1;

  // Internal strobes stay off while halted
  assert_no_strobe_in_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !(core_en_o || bus_en_o || peri_en_o));
  // Released pad reads as pulled high
  assert_pad_pullup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_pad_oe |-> ck_pad_o);
  // A wait begins only from a bus write with the PLL running (R8, R7)
  assert_halt_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_o) |-> $past(wr_valid && pll2_en && (wr_addr == ADDR_W'(SEL_BUS))));
endmodule

// File: tb/clk_ratio_sequencer_tb_top.sv
module clk_ratio_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid;
  logic       wr_ready;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       pll2_en;
  logic       halt_o, core_en_o, bus_en_o, peri_en_o, ck_pad_o, ck_pad_oe;

  int checks = 0;
  int fails  = 0;
  int halt_cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clk_ratio_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .pll2_en(pll2_en), .halt_o(halt_o),
    .core_en_o(core_en_o), .bus_en_o(bus_en_o), .peri_en_o(peri_en_o),
    .ck_pad_o(ck_pad_o), .ck_pad_oe(ck_pad_oe)
  );

  always @(negedge clk) if (halt_o) halt_cycles++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic int map_div(input int code, input int prev);
    if (code < 4) return code + 1;
    if (code == 4) return 6;
    if (code == 5) return 8;
    return prev;
  endfunction

  function automatic bit en_of(input int d);
    if (d == 0) return core_en_o;
    if (d == 1) return bus_en_o;
    return peri_en_o;
  endfunction

  task automatic measure(input int d, output int per);
    while (!en_of(d)) @(negedge clk);
    @(negedge clk);
    per = 1;
    while (!en_of(d)) begin @(negedge clk); per++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev_div [3];
    int per;
    int bus_div;
    wr_valid = 1'b0; wr_addr = '0; wr_data = '0; pll2_en = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(halt_o == 1'b0, "R4 reset halt", halt_o, 0);
    chk(ck_pad_oe == 1'b1, "R9 reset pad", ck_pad_oe, 1);
    chk(wr_ready == 1'b1, "R10 ready", wr_ready, 1);
    chk(core_en_o && bus_en_o && peri_en_o, "R1 reset div1", core_en_o, 1);

    // Full code sweep on every domain, PLL off
    for (int d = 0; d < 3; d++) begin
      prev_div[d] = 1;
      for (int c = 0; c < 8; c++) begin
        wr(d, c);
        prev_div[d] = map_div(c, prev_div[d]);
        repeat (20) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
          measure(d, per);
          chk(per == prev_div[d], (c > 5) ? "R2 reserved code" : "R1 period", per, prev_div[d]);
        end
      end
    end
    chk(halt_cycles == 0, "R7 no halt with PLL off", halt_cycles, 0);

    // R3: switching core from div8 to div3
    wr(0, 5);
    repeat (20) @(negedge clk);
    wr(0, 2);
    for (int k = 0; k < 4; k++) begin
      measure(0, per);
      chk(per == 8 || per == 3, "R3 boundary interval", per, 3);
    end
    chk(per == 3, "R3 settled", per, 3);

    // R8: core and peripheral writes with PLL on
    pll2_en = 1'b1;
    wr(0, 3);
    wr(2, 4);
    repeat (10) @(negedge clk);
    chk(halt_cycles == 0, "R8 no halt", halt_cycles, 0);

    // R4/R5/R9: stabilization waits over several start values
    bus_div = prev_div[1];
    for (int t = 0; t < 5; t++) begin
      int pre, code, n, bad, padhi;
      pre  = (t == 0) ? 200 : (t == 1) ? 250 : (t == 2) ? 255 : (t == 3) ? 0 : 128;
      code = (t == 0) ? 0 : (t == 1) ? 3 : (t == 2) ? 5 : (t == 3) ? 1 : 4;
      wr(4, pre);
      wr(1, code);
      bus_div = map_div(code, bus_div);
      n = 0; bad = 0; padhi = 0;
      while (halt_o) begin
        n++;
        if (core_en_o || bus_en_o || peri_en_o) bad++;
        if (ck_pad_o) padhi++;
        @(negedge clk);
      end
      chk(n == 256 - pre, "R4 wait length", n, 256 - pre);
      chk(bad == 0, "R5 strobes gated", bad, 0);
      if (code == 0) chk(padhi >= n - 8, "R9 pad runs in wait", padhi, n - 8);
      repeat (20) @(negedge clk);
      measure(1, per);
      chk(per == bus_div, "R4 bus ratio after wait", per, bus_div);
    end

    // R6: second bus write during a wait
    begin
      int n;
      wr(4, 100);
      wr(1, 4);
      n = 0;
      while (halt_o) begin
        n++;
        if (n == 10) begin wr_valid = 1'b1; wr_addr = 3'd1; wr_data = 8'd1; end
        if (n == 11) wr_valid = 1'b0;
        @(negedge clk);
      end
      wr_valid = 1'b0;
      chk(n == 156, "R6 wait not restarted", n, 156);
      repeat (20) @(negedge clk);
      measure(1, per);
      chk(per == 6, "R6 second write ignored", per, 6);
    end

    // R7: bus write with PLL off applies without halt
    pll2_en = 1'b0;
    wr(1, 3);
    chk(halt_o == 1'b0, "R7 no halt", halt_o, 0);
    repeat (10) @(negedge clk);
    measure(1, per);
    chk(per == 4, "R7 new bus ratio", per, 4);

    // R9: pad follows bus strobe, then released
    begin
      int mism;
      mism = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (ck_pad_oe !== 1'b1 || ck_pad_o !== bus_en_o) mism++;
      end
      chk(mism == 0, "R9 pad follows bus", mism, 0);
      wr(3, 0);
      mism = 0;
      for (int k = 0; k < 20; k++) begin
        if (ck_pad_oe !== 1'b0 || ck_pad_o !== 1'b1) mism++;
        @(negedge clk);
      end
      chk(mism == 0, "R9 pad released high", mism, 0);
      wr(3, 1);
      chk(ck_pad_oe == 1'b1, "R9 pad re-enabled", ck_pad_oe, 1);
      chk(wr_ready == 1'b1, "R10 no back-pressure", wr_ready, 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule